// File: doc/BRIEF.md
# Up/Down Timer with Capture and Compare Clear

This block is a 16-bit event timer. A programmable prescaler divides the clock, and a counter steps up or down once per prescaler terminal count. An 8-bit control register starts and stops the count and picks the direction. It also arms two automatic clear sources: a capture into either capture register, or a compare-0 match reported by a neighbouring comparator. Any of these clears returns the counter to zero and reloads the prescaler. Writing the one-shot clear bit in the control register also clears the counter. That bit never stays set.

Two capture triggers copy the live count into two capture registers. They do this whether or not the counter is running. A global enable input from the chip gates the local run bit, and the chip holds this input high after reset. Hardware can force the direction through a pair of inputs. A wrap past the top or bottom of the count range is remembered. The next capture into register 0 moves that record into a read-only flag.

Top module: `updn_timer`

## Requirements
- R1: After reset the control register reads 00h, the prescaler register reads 00h, and the counter and both capture registers read 0000h. Read addresses: 0 control, 1 prescaler, 2/3 counter low/high byte, 4/5 capture 0 low/high, 6/7 capture 1 low/high.
- R2: The counter moves only in cycles where control bit 7 and `gbl_en` are both 1. Control bit 0 reads 1 exactly when both are 1.
- R3: While stopped, the counter holds its value. Setting bit 7 again resumes counting from the held value, with no reload.
- R4: When `hw_dir_force` is 1, `hw_dir_up` sets the direction. Otherwise control bit 3 sets it (1 = up, 0 = down). Control bit 2 reads the direction in effect.
- R5: With N written at address 1, the counter takes one step every N+1 running cycles, counted from a prescaler reload.
- R6: Counting up from FFFFh gives 0000h, and counting down from 0000h gives FFFFh. Each of these wraps records a pending wrap.
- R7: A one-cycle pulse on `cap0_trig` or `cap1_trig` copies the counter value from before that edge into capture register 0 or 1. This happens even while the counter is stopped.
- R8: With control bit 6 set, a capture on either trigger also clears the counter and reloads the prescaler. With bit 6 clear, a capture leaves the counter unchanged.
- R9: With control bit 5 set, a `cmp0_match` pulse clears the counter and reloads the prescaler. With bit 5 clear, the pulse has no effect.
- R10: Writing 1 to control bit 4 clears the counter and reloads the prescaler at that edge. Bit 4 always reads 0.
- R11: A capture on register 0 loads control bit 1 with the pending-wrap state and then empties it. A second capture with no wrap in between reads 0.
- R12: Writes to control bits 2, 1 and 0 are ignored. Those bits only report state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gbl_en | input | 1 | Chip-wide count enable, ANDed with control bit 7 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cap0_trig | input | 1 | Capture strobe for capture register 0 |
| cap1_trig | input | 1 | Capture strobe for capture register 1 |
| cmp0_match | input | 1 | Compare-0 match strobe |
| hw_dir_force | input | 1 | Hardware takes over the count direction |
| hw_dir_up | input | 1 | Hardware direction, 1 = up |

## Verification
The hardest behaviour to show from the ports is the prescaler reload that comes with a compare clear. It only shows up while the counter is running with a divider above one. Even then, the first step after the clear arrives one or more cycles later than it would without the reload. The stimulus sets a divide-by-four ratio, starts the counter and fires the compare strobe mid-period. It then samples the counter at the exact cycles where a missing reload would already have produced a step. The wrap flag is reached in a similar way: the stimulus pulses the global enable for one cycle, which gives a single step onto the wrap boundary.

// File: rtl/updn_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions, register addresses and the stored
// control-register type for the up/down timer.
// Assumes an 8-bit register port and a counter twice that width.
package updn_timer_pkg;

    localparam int ADDR_W = 3;

    // Control register bit positions
    localparam int CB_RUN    = 7;
    localparam int CB_CLRCAP = 6;
    localparam int CB_CLRCMP = 5;
    localparam int CB_SWCLR  = 4;
    localparam int CB_UP     = 3;

    // Register read/write addresses
    localparam logic [ADDR_W-1:0] RA_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] RA_PSC     = 3'd1;
    localparam logic [ADDR_W-1:0] RA_CNT_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_CNT_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_CAP0_LO = 3'd4;
    localparam logic [ADDR_W-1:0] RA_CAP0_HI = 3'd5;
    localparam logic [ADDR_W-1:0] RA_CAP1_LO = 3'd6;
    localparam logic [ADDR_W-1:0] RA_CAP1_HI = 3'd7;

    // Writable control bits that are actually stored
    typedef struct packed {
        logic run_en;
        logic clr_cap;
        logic clr_cmp;
        logic up_sw;
    } tmr_ctrl_t;

endpackage

// File: rtl/utm_ctrl_reg.sv
`timescale 1ns/1ps
// Module: utm_ctrl_reg
// Holds the writable part of the control register and the prescaler
// divider. Bit 4 of a control write is not stored: it becomes a
// one-cycle clear request at the same edge. Read-only bits are
// never stored here.
// Assumes write strobes are synchronous to clk.
module utm_ctrl_reg
    import updn_timer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output tmr_ctrl_t         ctrl,
    output logic [DATA_W-1:0] psc_div,
    output logic              sw_clr
);

    logic ctrl_wr;
    logic psc_wr;

    // Decode which register a write strobe targets
    always_comb begin
        ctrl_wr = wr_en && (wr_addr == RA_CTRL);
        psc_wr  = wr_en && (wr_addr == RA_PSC);
        sw_clr  = ctrl_wr && wr_data[CB_SWCLR];
    end

    // Store the writable control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.run_en  <= wr_data[CB_RUN];
            ctrl.clr_cap <= wr_data[CB_CLRCAP];
            ctrl.clr_cmp <= wr_data[CB_CLRCMP];
            ctrl.up_sw   <= wr_data[CB_UP];
        end
    end

    // Store the prescaler divider value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_div <= '0;
        end else if (psc_wr) begin
            psc_div <= wr_data;
        end
    end

endmodule

// File: rtl/utm_prescaler.sv
`timescale 1ns/1ps
// Module: utm_prescaler
// Down-counting clock divider. A value of N in div gives one tick
// every N+1 running cycles. reload presets the count to div and
// takes priority over running. The count freezes while run is low.
// Assumes div is stable between reloads (a smaller new value takes
// effect at the next terminal count).
module utm_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt_q;
    logic             at_zero;

    // Terminal count detection
    always_comb begin
        at_zero = (pcnt_q == '0);
        tick    = run && at_zero;
    end

    // Divider count: reload, wrap at terminal count, or step down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (reload) begin
            pcnt_q <= div;
        end else if (run) begin
            pcnt_q <= at_zero ? div : pcnt_q - PSC_W'(1);
        end
    end

endmodule

// File: rtl/utm_counter.sv
`timescale 1ns/1ps
// Module: utm_counter
// Up/down counter with clear priority over stepping, a set of
// capture registers built by generate, and the wrap tracker.
// A capture copies the value from before the edge. A wrap sets a
// pending flag. A capture into register 0 moves that flag to
// wrap_seen and empties it; a wrap in that same cycle stays pending.
// Assumes tick is already gated by the run condition.
module utm_counter #(
    parameter int CNT_W = 16,
    parameter int NCAP  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       up,
    input  logic                       clr,
    input  logic [NCAP-1:0]            cap_trig,
    output logic [CNT_W-1:0]           cnt,
    output logic [NCAP-1:0][CNT_W-1:0] cap_val,
    output logic                       wrap_seen
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic step;
    logic wrap_now;
    logic wrap_pend_q;

    // A step happens on a tick unless a clear wins; detect boundary wrap
    always_comb begin
        step     = tick && !clr;
        wrap_now = step && (up ? (cnt == CNT_MAX) : (cnt == '0));
    end

    // Main count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
        end
    end

    // One capture register per trigger
    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        // Copy the pre-edge count on this trigger
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_val[g] <= '0;
            end else if (cap_trig[g]) begin
                cap_val[g] <= cnt;
            end
        end
    end

    // Pending wrap record, emptied by a capture into register 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_pend_q <= 1'b0;
        end else if (cap_trig[0]) begin
            wrap_pend_q <= wrap_now;
        end else if (wrap_now) begin
            wrap_pend_q <= 1'b1;
        end
    end

    // Visible wrap flag latched at capture-0 time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_seen <= 1'b0;
        end else if (cap_trig[0]) begin
            wrap_seen <= wrap_pend_q;
        end
    end

endmodule

// File: rtl/updn_timer.sv
`timescale 1ns/1ps
// Module: updn_timer (top)
// 16-bit up/down timer with prescaler, two capture registers,
// automatic clear on capture or compare-0, one-shot software clear
// and global enable gating. Register reads are combinational.
// Assumes all strobes are single-cycle and synchronous to clk.
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gbl_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cap0_trig,
    input  logic              cap1_trig,
    input  logic              cmp0_match,
    input  logic              hw_dir_force,
    input  logic              hw_dir_up
);

    localparam int CNT_W = 2 * DATA_W;
    localparam int NCAP  = 2;

    tmr_ctrl_t                  ctrl_q;
    logic [DATA_W-1:0]          psc_div;
    logic                       sw_clr;
    logic                       running;
    logic                       cnt_up;
    logic                       clr_any;
    logic                       psc_tick;
    logic [NCAP-1:0]            cap_trig;
    logic [CNT_W-1:0]           cnt;
    logic [NCAP-1:0][CNT_W-1:0] cap_val;
    logic                       wrap_seen;
    logic [DATA_W-1:0]          ctrl_rd;

    // Run gating, direction choice and merged clear sources
    always_comb begin
        cap_trig = {cap1_trig, cap0_trig};
        running  = ctrl_q.run_en && gbl_en;
        cnt_up   = hw_dir_force ? hw_dir_up : ctrl_q.up_sw;
        clr_any  = sw_clr
                 || (ctrl_q.clr_cap && (|cap_trig))
                 || (ctrl_q.clr_cmp && cmp0_match);
    end

    utm_ctrl_reg #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl_q),
        .psc_div (psc_div),
        .sw_clr  (sw_clr)
    );

    utm_prescaler #(
        .PSC_W (DATA_W)
    ) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running),
        .reload (clr_any),
        .div    (psc_div),
        .tick   (psc_tick)
    );

    utm_counter #(
        .CNT_W (CNT_W),
        .NCAP  (NCAP)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (psc_tick),
        .up        (cnt_up),
        .clr       (clr_any),
        .cap_trig  (cap_trig),
        .cnt       (cnt),
        .cap_val   (cap_val),
        .wrap_seen (wrap_seen)
    );

    // Assemble the control register read view
    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[CB_RUN]    = ctrl_q.run_en;
        ctrl_rd[CB_CLRCAP] = ctrl_q.clr_cap;
        ctrl_rd[CB_CLRCMP] = ctrl_q.clr_cmp;
        ctrl_rd[CB_UP]     = ctrl_q.up_sw;
        ctrl_rd[2]         = cnt_up;
        ctrl_rd[1]         = wrap_seen;
        ctrl_rd[0]         = running;
    end

    // Read data multiplexer
    always_comb begin
        unique case (rd_addr)
            RA_CTRL:    rd_data = ctrl_rd;
            RA_PSC:     rd_data = psc_div;
            RA_CNT_LO:  rd_data = cnt[DATA_W-1:0];
            RA_CNT_HI:  rd_data = cnt[CNT_W-1:DATA_W];
            RA_CAP0_LO: rd_data = cap_val[0][DATA_W-1:0];
            RA_CAP0_HI: rd_data = cap_val[0][CNT_W-1:DATA_W];
            RA_CAP1_LO: rd_data = cap_val[1][DATA_W-1:0];
            RA_CAP1_HI: rd_data = cap_val[1][CNT_W-1:DATA_W];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/utm_checker.sv
`timescale 1ns/1ps
// Module: utm_checker
// Temporal checks on the timer, attached to every updn_timer
// instance by the bind below. Observes only; drives nothing.
module utm_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gbl_en,
    input logic              run_en,
    input logic              clr_cap,
    input logic              clr_cmp,
    input logic              clr_any,
    input logic              tick,
    input logic              up,
    input logic              cap0_trig,
    input logic              cap1_trig,
    input logic              cmp0_match,
    input logic [2:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cap0_val
);

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_en && gbl_en) && !clr_any) |=> $stable(cnt));

    a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !clr_any) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    a_r6_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up && !clr_any) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

    a_r7_cap0_copies: assert property (@(posedge clk) disable iff (!rst_n)
        cap0_trig |=> (cap0_val == $past(cnt)));

    a_r8_clear_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cap && (cap0_trig || cap1_trig)) |=> (cnt == '0));

    a_r9_clear_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmp && cmp0_match) |=> (cnt == '0));

    a_r10_clear_bit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd0) |-> !rd_data[4]);

endmodule

bind updn_timer utm_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gbl_en     (gbl_en),
    .run_en     (ctrl_q.run_en),
    .clr_cap    (ctrl_q.clr_cap),
    .clr_cmp    (ctrl_q.clr_cmp),
    .clr_any    (clr_any),
    .tick       (psc_tick),
    .up         (cnt_up),
    .cap0_trig  (cap0_trig),
    .cap1_trig  (cap1_trig),
    .cmp0_match (cmp0_match),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cnt        (cnt),
    .cap0_val   (cap_val[0])
);

// File: tb/test_updn_timer.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected register reads and a
// monitor pops them five units after each rising edge and compares.
module test_updn_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gbl_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cap0_trig = 1'b0;
    logic       cap1_trig = 1'b0;
    logic       cmp0_match = 1'b0;
    logic       hw_dir_force = 1'b0;
    logic       hw_dir_up = 1'b0;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [2:0] a_q[$];
    logic [7:0] v_q[$];
    string      t_q[$];

    always #10 clk = ~clk;

    updn_timer i_updn_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .gbl_en       (gbl_en),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .cap0_trig    (cap0_trig),
        .cap1_trig    (cap1_trig),
        .cmp0_match   (cmp0_match),
        .hw_dir_force (hw_dir_force),
        .hw_dir_up    (hw_dir_up)
    );

    // Monitor: pop expected reads after each edge and compare
    always @(posedge clk) begin
        #5;
        while (a_q.size() > 0) begin
            logic [7:0] ev;
            string      tg;
            rd_addr = a_q.pop_front();
            ev = v_q.pop_front();
            tg = t_q.pop_front();
            #1;
            n_vec++;
            if (rd_data !== ev) begin
                n_fail++;
                $display("FAIL %s: addr %0d actual %02h expected %02h", tg, rd_addr, rd_data, ev);
            end
        end
    end

    task automatic exp8(input logic [2:0] a, input logic [7:0] v, input string t);
        a_q.push_back(a);
        v_q.push_back(v);
        t_q.push_back(t);
    endtask

    task automatic exp16(input logic [2:0] base, input logic [15:0] v, input string t);
        exp8(base, v[7:0], t);
        exp8(base + 3'd1, v[15:8], t);
    endtask

    task automatic settle();
        wait (a_q.size() == 0);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_cap(input bit second);
        @(negedge clk);
        if (second) cap1_trig = 1'b1; else cap0_trig = 1'b1;
        @(negedge clk);
        cap0_trig = 1'b0;
        cap1_trig = 1'b0;
    endtask

    // Driver: stimulus sequence with expected results
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp8(3'd0, 8'h00, "R1 ctrl");
        exp8(3'd1, 8'h00, "R1 psc");
        exp16(3'd2, 16'h0000, "R1 cnt");
        settle();
        exp16(3'd4, 16'h0000, "R1 cap0");
        exp16(3'd6, 16'h0000, "R1 cap1");
        settle();

        // R2 and R3: run up, stop, hold, resume
        wr(3'd0, 8'h88);
        repeat (4) @(negedge clk);
        wr(3'd0, 8'h08);
        exp16(3'd2, 16'd6, "R2 up count");
        exp8(3'd0, 8'h0C, "R4 sw up status");
        settle();
        repeat (5) @(negedge clk);
        exp16(3'd2, 16'd6, "R3 hold while stopped");
        settle();
        wr(3'd0, 8'h88);
        wr(3'd0, 8'h08);
        exp16(3'd2, 16'd8, "R3 resume no reload");
        settle();

        // R10 software clear, R6 down wrap, R11 flag, R7 stopped capture
        wr(3'd0, 8'h10);
        exp16(3'd2, 16'h0000, "R10 sw clear");
        exp8(3'd0, 8'h00, "R10 bit reads zero");
        settle();
        wr(3'd0, 8'h80);
        wr(3'd0, 8'h00);
        exp16(3'd2, 16'hFFFE, "R6 down wrap");
        settle();
        pulse_cap(1'b0);
        exp16(3'd4, 16'hFFFE, "R7 capture stopped");
        exp8(3'd0, 8'h02, "R11 wrap latched");
        settle();
        pulse_cap(1'b0);
        exp8(3'd0, 8'h00, "R11 flag emptied");
        settle();

        // R2 global enable gating, R6 up wrap
        @(negedge clk);
        gbl_en = 1'b0;
        wr(3'd0, 8'h88);
        exp8(3'd0, 8'h8C, "R2 global low");
        exp16(3'd2, 16'hFFFE, "R2 global low hold");
        settle();
        @(negedge clk);
        gbl_en = 1'b1;
        exp8(3'd0, 8'h8D, "R2 running status");
        exp16(3'd2, 16'hFFFF, "R2 one step");
        settle();
        @(negedge clk);
        gbl_en = 1'b0;
        @(negedge clk);
        gbl_en = 1'b1;
        @(negedge clk);
        gbl_en = 1'b0;
        exp16(3'd2, 16'h0000, "R6 up wrap");
        settle();
        wr(3'd0, 8'h08);
        gbl_en = 1'b1;
        pulse_cap(1'b0);
        exp16(3'd4, 16'h0000, "R7 capture");
        exp8(3'd0, 8'h0E, "R11 up wrap latched");
        settle();

        // R4 hardware direction override
        hw_dir_force = 1'b1;
        hw_dir_up = 1'b0;
        exp8(3'd0, 8'h0A, "R4 forced down status");
        settle();
        wr(3'd0, 8'h88);
        wr(3'd0, 8'h08);
        exp16(3'd2, 16'hFFFE, "R4 forced down count");
        settle();
        hw_dir_force = 1'b0;
        exp8(3'd0, 8'h0E, "R4 released");
        settle();

        // R12 read-only bits ignore writes
        wr(3'd0, 8'h07);
        exp8(3'd0, 8'h02, "R12 ro bits");
        exp16(3'd2, 16'hFFFE, "R12 cnt untouched");
        settle();
        wr(3'd0, 8'h08);

        // R5 prescaler divide by four
        wr(3'd1, 8'h03);
        exp8(3'd1, 8'h03, "R5 psc reg");
        settle();
        wr(3'd0, 8'h18);
        wr(3'd0, 8'h88);
        repeat (10) @(negedge clk);
        wr(3'd0, 8'h08);
        exp16(3'd2, 16'd3, "R5 divided steps");
        settle();

        // R9 compare clear with prescaler reload
        wr(3'd0, 8'hA8);
        cmp0_match = 1'b1;
        @(negedge clk);
        cmp0_match = 1'b0;
        exp16(3'd2, 16'd0, "R9 compare clear");
        settle();
        repeat (2) @(negedge clk);
        exp16(3'd2, 16'd0, "R9 prescaler reloaded");
        settle();
        exp16(3'd2, 16'd1, "R9 first step after reload");
        settle();
        wr(3'd0, 8'h28);
        exp16(3'd2, 16'd1, "R9 stopped");
        settle();
        wr(3'd0, 8'h08);
        @(negedge clk);
        cmp0_match = 1'b1;
        @(negedge clk);
        cmp0_match = 1'b0;
        exp16(3'd2, 16'd1, "R9 compare disarmed");
        settle();

        // R8 clear on capture, R7 capture values
        wr(3'd0, 8'h48);
        pulse_cap(1'b1);
        exp16(3'd6, 16'd1, "R7 cap1 pre-clear value");
        exp16(3'd2, 16'd0, "R8 capture clear");
        settle();
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h18);
        wr(3'd0, 8'h88);
        wr(3'd0, 8'h08);
        pulse_cap(1'b1);
        exp16(3'd6, 16'd2, "R7 cap1");
        exp16(3'd2, 16'd2, "R8 capture clear disarmed");
        settle();
        wr(3'd0, 8'h48);
        pulse_cap(1'b0);
        exp16(3'd2, 16'd0, "R8 cap0 clear");
        exp16(3'd4, 16'd2, "R7 cap0");
        settle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1-sequence: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule